// File: doc/BRIEF.md
# Line-Signaling Input Conditioner

This block serves the control pins of a four-line subscriber interface. Each line has five general-purpose pins: two signaling pins (SIG_A and SIG_B) and three plain control pins (AUX0, AUX1, AUX2). A direction bit for each pin selects how the pin is used. An output pin drives a latched level. An input pin is brought into the clock domain and then conditioned:

- SIG_A passes through a millisecond debouncer.
- SIG_B passes through a saturating up/down-count filter that samples at a programmed interval.
- The AUX pins pass straight through.

In split mode a line carries two time-multiplexed signals on SIG_A: a hook/ring-trip bit and a ground-key bit. A phase select marks which of the two is present. Each signal is captured on its own phase. The hook bit feeds the debouncer. The ground-key bit takes the place of the SIG_B pin in front of the filter.

The conditioned bits of each line are available as a five-bit group. The conditioned SIG_A and SIG_B of all lines are also packed into one snapshot word, so a single read returns them all. The configuration inputs are plain register values held by an outside decoder. No data stream crosses this block, so every port is a plain level with no valid/ready handshake. The millisecond tick is a one-cycle pulse.

Top module: `line_sig_cond`

## Requirements
- R1: Pin index c*5+p belongs to line c, with p=0 SIG_A, p=1 SIG_B, p=2..4 AUX0..AUX2. `pin_oe` bit = `cfg_dir` bit (1 = output, 0 = input) while out of reset.
- R2: For an output pin, `pin_out` drives its `cfg_out` bit and holds it until that bit is rewritten. For an input pin, `pin_out` is 0.
- R3: With a debounce setting N in 1..15, conditioned SIG_A takes a new level only after the synchronized input has differed from the output on N consecutive ticks. A return to the old level restarts the count.
- R4: With a debounce setting of 0, conditioned SIG_A follows the synchronized input on the next clock, without waiting for a tick.
- R5: The SIG_B filter count rises on a high sample and falls on a low sample, saturating at 0 and at 7. The output goes high when the count reaches 7, goes low when it reaches 0, and holds in between.
- R6: A sample interval value S makes the filter sample on every (S+1)-th tick counted from reset. Ticks in between leave the count unchanged.
- R7: In split mode, SIG_A samples taken while `split_phase`=0 feed the debouncer, and samples taken while `split_phase`=1 feed the filter. The SIG_B pin level has no effect, and each captured signal holds during the other phase.
- R8: Input AUX pins appear in `ch_bits` after the two-stage synchronizer, with no conditioning.
- R9: A pin set as output reports its latched `cfg_out` value in `ch_bits`.
- R10: `snap` bit 2c holds conditioned SIG_A of line c, and bit 2c+1 holds conditioned SIG_B of line c. They are the same values that appear in `ch_bits`.
- R11: While `rst_n` is low, all pins are inputs (`pin_oe`=0). After reset, all conditioned bits and `snap` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| split_phase | input | 1 | Split-mode phase: 0 hook bit, 1 ground-key bit |
| pin_in | input | NUM_CH*5 | Raw pin levels |
| cfg_dir | input | NUM_CH*5 | Direction per pin, 1 = output |
| cfg_out | input | NUM_CH*5 | Latched output level per pin |
| cfg_deb | input | NUM_CH*DEB_W | Debounce ticks per line |
| cfg_samp | input | NUM_CH*SAMP_W | Filter sample interval per line (ticks minus one) |
| cfg_split | input | NUM_CH | Split-mode enable per line |
| pin_out | output | NUM_CH*5 | Pin drive value |
| pin_oe | output | NUM_CH*5 | Pin drive enable |
| ch_bits | output | NUM_CH*5 | Conditioned bits per line |
| snap | output | NUM_CH*2 | Packed SIG_A/SIG_B of all lines |

## Verification
The bench builds the block with its defaults: four lines, a 4-bit debounce field, a filter limit of 7, a 4-bit sample interval and two synchronizer stages. The bench drives the millisecond tick itself rather than waiting for real time. This brings within a few hundred cycles the full 15-tick debounce extreme, both saturation ends of the filter, a three-tick sample interval and a complete split-mode exchange. Four lines are enough to give the snapshot word a mixed pattern in which every bit position is distinguishable.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int PINS_PER_CH = 5;
  localparam int IDX_SIGA    = 0;
  localparam int IDX_SIGB    = 1;
  localparam int IDX_AUX0    = 2;
  localparam int NUM_AUX     = 3;
endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lsc_debounce.sv
module lsc_debounce #(
  parameter int DEB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic [DEB_W-1:0] deb_time,
  input  logic             din,
  output logic             dout
);
  logic [DEB_W-1:0] cnt_q;
  logic [DEB_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      cnt_q <= '0;
    end else if (deb_time == '0) begin
      dout  <= din;
      cnt_q <= '0;
    end else if (din == dout) begin
      cnt_q <= '0;
    end else if (tick_ms) begin
      if (cnt_inc >= {1'b0, deb_time}) begin
        dout  <= din;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_inc[DEB_W-1:0];
      end
    end
  end

  // R4: zero setting tracks the input one clock later
  a_r4_zero_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_time == '0) |=> (dout == $past(din)));
  // R3: with a nonzero setting the output moves only on a tick
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_ms && deb_time != '0) |=> $stable(dout));
endmodule

// File: rtl/lsc_updown_filter.sv
module lsc_updown_filter #(
  parameter int LIMIT  = 7,
  parameter int SAMP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic [SAMP_W-1:0] samp_int,
  input  logic              din,
  output logic              dout
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [SAMP_W-1:0] div_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              sample;

  assign sample = tick_ms && (div_q >= samp_int);

  always_comb begin
    cnt_nxt = cnt_q;
    if (sample) begin
      if (din && cnt_q != LIM)       cnt_nxt = cnt_q + 1'b1;
      else if (!din && cnt_q != '0)  cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      dout  <= 1'b0;
    end else begin
      if (tick_ms) div_q <= sample ? '0 : div_q + 1'b1;
      cnt_q <= cnt_nxt;
      if (cnt_nxt == LIM)      dout <= 1'b1;
      else if (cnt_nxt == '0)  dout <= 1'b0;
    end
  end

  // R5: count never leaves its range
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  // R5: output rises only with the count at its limit
  a_r5_rise_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout) |-> (cnt_q == LIM));
  // R6: no tick, no movement of the count
  a_r6_idle_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_ms |=> $stable(cnt_q));
endmodule

// File: rtl/lsc_channel.sv
module lsc_channel
  import lsc_pkg::*;
#(
  parameter int DEB_W  = 4,
  parameter int SAMP_W = 4,
  parameter int LIMIT  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_ms,
  input  logic                   phase_s,
  input  logic [PINS_PER_CH-1:0] pin_s,
  input  logic [PINS_PER_CH-1:0] dir_eff,
  input  logic [PINS_PER_CH-1:0] out_val,
  input  logic [DEB_W-1:0]       deb_time,
  input  logic [SAMP_W-1:0]      samp_int,
  input  logic                   split_en,
  output logic [PINS_PER_CH-1:0] cond
);
  logic hook_q, gkey_q;
  logic deb_in, filt_in, deb_out, filt_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hook_q <= 1'b0;
      gkey_q <= 1'b0;
    end else if (split_en) begin
      if (phase_s) gkey_q <= pin_s[IDX_SIGA];
      else         hook_q <= pin_s[IDX_SIGA];
    end
  end

  assign deb_in  = split_en ? hook_q : pin_s[IDX_SIGA];
  assign filt_in = split_en ? gkey_q : pin_s[IDX_SIGB];

  lsc_debounce #(.DEB_W(DEB_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .deb_time(deb_time), .din(deb_in), .dout(deb_out)
  );

  lsc_updown_filter #(.LIMIT(LIMIT), .SAMP_W(SAMP_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .samp_int(samp_int), .din(filt_in), .dout(filt_out)
  );

  always_comb begin
    cond[IDX_SIGA] = dir_eff[IDX_SIGA] ? out_val[IDX_SIGA] : deb_out;
    cond[IDX_SIGB] = dir_eff[IDX_SIGB] ? out_val[IDX_SIGB] : filt_out;
  end

  for (genvar a = 0; a < NUM_AUX; a++) begin : g_aux
    assign cond[IDX_AUX0+a] = dir_eff[IDX_AUX0+a] ? out_val[IDX_AUX0+a]
                                                  : pin_s[IDX_AUX0+a];
  end

  // R7: the hook capture holds through the ground-key phase
  a_r7_hook_held: assert property (@(posedge clk) disable iff (!rst_n)
    (split_en && phase_s) |=> $stable(hook_q));
  // R7: the ground-key capture holds through the hook phase
  a_r7_gkey_held: assert property (@(posedge clk) disable iff (!rst_n)
    (split_en && !phase_s) |=> $stable(gkey_q));
endmodule

// File: rtl/line_sig_cond.sv
module line_sig_cond
  import lsc_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DEB_W       = 4,
  parameter int SAMP_W      = 4,
  parameter int FILT_LIMIT  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick_ms,
  input  logic                          split_phase,
  input  logic [NUM_CH*PINS_PER_CH-1:0] pin_in,
  input  logic [NUM_CH*PINS_PER_CH-1:0] cfg_dir,
  input  logic [NUM_CH*PINS_PER_CH-1:0] cfg_out,
  input  logic [NUM_CH*DEB_W-1:0]       cfg_deb,
  input  logic [NUM_CH*SAMP_W-1:0]      cfg_samp,
  input  logic [NUM_CH-1:0]             cfg_split,
  output logic [NUM_CH*PINS_PER_CH-1:0] pin_out,
  output logic [NUM_CH*PINS_PER_CH-1:0] pin_oe,
  output logic [NUM_CH*PINS_PER_CH-1:0] ch_bits,
  output logic [NUM_CH*2-1:0]           snap
);
  localparam int PW = NUM_CH * PINS_PER_CH;

  logic [PW-1:0] pin_s;
  logic          phase_s;
  logic [PW-1:0] dir_eff;

  lsc_sync #(.W(PW + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({split_phase, pin_in}),
    .q({phase_s, pin_s})
  );

  assign dir_eff = rst_n ? cfg_dir : '0;
  assign pin_oe  = dir_eff;
  assign pin_out = cfg_out & dir_eff;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lsc_channel #(.DEB_W(DEB_W), .SAMP_W(SAMP_W), .LIMIT(FILT_LIMIT)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_ms  (tick_ms),
      .phase_s  (phase_s),
      .pin_s    (pin_s[c*PINS_PER_CH +: PINS_PER_CH]),
      .dir_eff  (dir_eff[c*PINS_PER_CH +: PINS_PER_CH]),
      .out_val  (cfg_out[c*PINS_PER_CH +: PINS_PER_CH]),
      .deb_time (cfg_deb[c*DEB_W +: DEB_W]),
      .samp_int (cfg_samp[c*SAMP_W +: SAMP_W]),
      .split_en (cfg_split[c]),
      .cond     (ch_bits[c*PINS_PER_CH +: PINS_PER_CH])
    );
    assign snap[2*c]   = ch_bits[c*PINS_PER_CH + IDX_SIGA];
    assign snap[2*c+1] = ch_bits[c*PINS_PER_CH + IDX_SIGB];
  end

  // R2: an unchanged configuration leaves the pin drive unchanged
  a_r2_drive_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_out == $past(cfg_out) && cfg_dir == $past(cfg_dir)) |-> $stable(pin_out));
  // R1: the drive value never shows on a pin that is not enabled
  a_r1_no_drive_when_input: assert property (@(posedge clk)
    (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/line_sig_cond_tb.sv
module line_sig_cond_tb;
  localparam int NCH = 4;
  localparam int PW  = NCH * 5;

  logic clk = 0, rst_n = 0, tick_ms = 0, split_phase = 0;
  logic [PW-1:0] pin_in = '0, cfg_dir = '0, cfg_out = '0;
  logic [NCH*4-1:0] cfg_deb = '0, cfg_samp = '0;
  logic [NCH-1:0] cfg_split = '0;
  logic [PW-1:0] pin_out, pin_oe, ch_bits;
  logic [NCH*2-1:0] snap;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  line_sig_cond u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .split_phase(split_phase),
    .pin_in(pin_in), .cfg_dir(cfg_dir), .cfg_out(cfg_out), .cfg_deb(cfg_deb),
    .cfg_samp(cfg_samp), .cfg_split(cfg_split), .pin_out(pin_out),
    .pin_oe(pin_oe), .ch_bits(ch_bits), .snap(snap)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1;
      @(negedge clk) tick_ms = 0;
    end
    wait_clk(2);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    wait_clk(2);
    rst_n = 1;
    wait_clk(1);
  endtask

  task automatic t_reset();
    cfg_dir = '1; cfg_out = '1; pin_in = '1;
    @(negedge clk) rst_n = 0;
    wait_clk(1);
    check("R11 oe in reset", pin_oe, 0);
    cfg_dir = '0; cfg_out = '0; pin_in = '0;
    rst_n = 1;
    wait_clk(1);
    check("R11 ch_bits after reset", ch_bits, 0);
    check("R11 snap after reset", snap, 0);
  endtask

  task automatic t_outputs();
    do_reset();
    cfg_dir[13] = 1; cfg_out[13] = 1;
    cfg_dir[15] = 1; cfg_out[15] = 1;
    cfg_out[0] = 1;
    wait_clk(1);
    check("R1 oe", pin_oe, 32'h0A000);
    check("R2 drive", pin_out, 32'h0A000);
    wait_clk(5);
    check("R2 held", pin_out, 32'h0A000);
    check("R9 readback", ch_bits[15], 1);
    check("R10 snap readback", snap[6], 1);
    cfg_out[13] = 0; wait_clk(1);
    check("R2 rewritten", pin_out, 32'h08000);
    cfg_dir = '0; cfg_out = '0;
  endtask

  task automatic t_passthru();
    do_reset();
    pin_in[15] = 1;
    pin_in[7] = 1; pin_in[9] = 1;
    wait_clk(1);
    check("R8 not yet through sync", ch_bits[9:7], 0);
    wait_clk(3);
    check("R4 zero debounce follows", ch_bits[15], 1);
    check("R8 aux passthru", ch_bits[9:7], 3'b101);
    pin_in[15] = 0; wait_clk(4);
    check("R4 zero debounce falls", ch_bits[15], 0);
    pin_in = '0;
  endtask

  task automatic t_debounce();
    do_reset();
    cfg_deb[3:0] = 3;
    pin_in[0] = 1; wait_clk(4);
    ticks(2);
    check("R3 held before N ticks", ch_bits[0], 0);
    pin_in[0] = 0; wait_clk(4);
    pin_in[0] = 1; wait_clk(4);
    ticks(2);
    check("R3 bounce restarts count", ch_bits[0], 0);
    ticks(1);
    check("R3 changes at N ticks", ch_bits[0], 1);
    cfg_deb[3:0] = 15;
    pin_in[0] = 0; wait_clk(4);
    ticks(14);
    check("R3 held at 14 of 15", ch_bits[0], 1);
    ticks(1);
    check("R3 changes at 15", ch_bits[0], 0);
    cfg_deb = '0; pin_in = '0;
  endtask

  task automatic t_filter();
    do_reset();
    pin_in[6] = 1; wait_clk(4);
    ticks(6);
    check("R5 below limit", ch_bits[6], 0);
    ticks(1);
    check("R5 high at limit", ch_bits[6], 1);
    ticks(3);
    pin_in[6] = 0; wait_clk(4); ticks(1);
    pin_in[6] = 1; wait_clk(4); ticks(1);
    check("R5 glitch ignored", snap[3], 1);
    pin_in[6] = 0; wait_clk(4);
    ticks(6);
    check("R5 holds above zero", ch_bits[6], 1);
    ticks(1);
    check("R5 low at zero", ch_bits[6], 0);
    pin_in = '0;
  endtask

  task automatic t_interval();
    do_reset();
    cfg_samp[7:4] = 2;
    pin_in[6] = 1; wait_clk(4);
    ticks(20);
    check("R6 six samples in 20 ticks", ch_bits[6], 0);
    ticks(1);
    check("R6 seventh sample at tick 21", ch_bits[6], 1);
    cfg_samp = '0; pin_in = '0;
  endtask

  task automatic t_split();
    do_reset();
    cfg_split[0] = 1;
    pin_in[1] = 1;
    split_phase = 0; pin_in[0] = 1; wait_clk(4);
    split_phase = 1; pin_in[0] = 0; wait_clk(6);
    check("R7 hook captured and held", ch_bits[0], 1);
    ticks(8);
    check("R7 sig_b pin ignored", ch_bits[1], 0);
    pin_in[0] = 1; wait_clk(4);
    ticks(7);
    check("R7 ground key filtered", ch_bits[1], 1);
    split_phase = 0; pin_in[0] = 0; wait_clk(6);
    check("R7 hook follows phase 0", ch_bits[0], 0);
    check("R7 ground key held in phase 0", ch_bits[1], 1);
    cfg_split = '0; split_phase = 0; pin_in = '0;
  endtask

  task automatic t_snapshot();
    logic [3:0] a, b;
    logic [7:0] exp;
    do_reset();
    a = 4'b1101; b = 4'b0110;
    for (int c = 0; c < NCH; c++) begin
      pin_in[c*5]   = a[c];
      pin_in[c*5+1] = b[c];
    end
    wait_clk(4);
    ticks(7);
    for (int c = 0; c < NCH; c++) begin
      exp[2*c] = a[c]; exp[2*c+1] = b[c];
    end
    check("R10 snapshot pattern", snap, exp);
    check("R10 line2 group", ch_bits[11:10], {b[2], a[2]});
    pin_in = '0;
  endtask

  initial begin
    wait_clk(2);
    t_reset();
    t_outputs();
    t_passthru();
    t_debounce();
    t_filter();
    t_interval();
    t_split();
    t_snapshot();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule